// File: doc/BRIEF.md
# ADC Power and Conversion-Start Sequencer

This block is the digital control core that decides when an ADC's analog section is powered and when a conversion begins. It combines the enable bit, a run-in-standby bit, an on-demand bit and the present sleep state into a single "operation allowed" decision. It then drives a four-state machine that powers the analog section, waits out a programmable start-up delay and issues conversion-start pulses. Several hardware event lines can request a start, and several others can request a flush. Any one line of a group is enough, and a flush always wins over a start that arrives in the same cycle.

Operation has two forms. In continuous mode (on-demand bit clear) the analog section stays powered for as long as operation is allowed, and a start request begins a conversion on the next clock. In on-demand mode the analog section is normally off. A start request raises a one-cycle wake request and powers the analog section, and a down-counter loaded from the delay input holds the start pulse back until it has run out. The conversion-complete strobe then turns the power off again.

The states are OFF (unpowered idle), READY (powered idle, continuous mode), WARM (powered, start-up delay running) and CONV (conversion in progress). Every transition is taken on the clock edge:
- Not allowed, from any state: to OFF.
- Flush, from any state: to OFF in on-demand mode, otherwise to READY.
- OFF to READY: continuous mode is selected.
- OFF to WARM: on-demand start request; the wake request pulses and the timer loads.
- READY to OFF: on-demand mode is selected.
- READY to CONV: start request; the start pulse fires.
- WARM to CONV: the timer is at zero; the start pulse fires.
- CONV to READY or OFF: the conversion-complete strobe, going to OFF in on-demand mode.

Top module: `adc_pwr_seq`

## Requirements
- R1: With `en`=0, on the next clock `ana_pwr` is 0 and no `conv_start`, `wake_req` or `flush_pulse` is issued, whatever the other control bits and events are.
- R2: With `en`=1, `run_stby`=0 and `in_standby`=1, on the next clock `ana_pwr` is 0 and start events are not acted upon. With `in_standby`=0 under the same bits, operation is allowed.
- R3: With `run_stby`=1, operation is allowed while `in_standby`=1.
- R4: In continuous mode (`on_demand`=0, operation allowed), `ana_pwr` goes to 1 one clock after operation becomes allowed and stays at 1. A start event seen in READY makes `conv_start` 1 on the following clock.
- R5: In on-demand mode, a start event seen in OFF makes `wake_req` 1 and `ana_pwr` 1 on the following clock. `conv_start` then pulses exactly `su_delay`+1 clocks after `wake_req`.
- R6: In on-demand mode, `conv_done` seen in CONV makes `ana_pwr` 0 on the following clock.
- R7: Each bit of `evt_start` on its own requests a start; the start request is the OR of all bits.
- R8: When any `evt_flush` bit is 1 while `en`=1, `flush_pulse` is 1 on the next clock and `conv_start` is not, even if a start event is present in the same cycle. A conversion in progress is abandoned: the state becomes READY in continuous mode or OFF in on-demand mode.
- R9: `conv_start`, `wake_req` and `flush_pulse` last one cycle each, and at most one of them is 1 in any cycle. A start event in CONV issues no `conv_start`.
- R10: Synchronous reset `rst` puts the block in OFF with `ana_pwr` 0, no pulses and the timer cleared. An on-demand sequence started after reset has the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable |
| run_stby | input | 1 | Permit operation in standby sleep |
| on_demand | input | 1 | 1 = power analog section only per request |
| in_standby | input | 1 | 1 = system is in standby sleep |
| evt_start | input | N_EVT | Start event lines, ORed |
| evt_flush | input | N_EVT | Flush event lines, ORed |
| conv_done | input | 1 | Conversion-complete strobe from the converter |
| su_delay | input | DLY_W | Start-up delay in clocks for on-demand mode |
| ana_pwr | output | 1 | Analog section power enable |
| conv_start | output | 1 | One-cycle conversion-start pulse |
| flush_pulse | output | 1 | One-cycle flush pulse |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The bench drives a start and a flush together in the same cycle. A design with the priority the wrong way round would emit `conv_start` there and leave the flush out. It counts the clocks from `wake_req` to `conv_start` with delays of 3 and 0, which catches an off-by-one timer or a timer that ignores a zero load. It also checks that a start event during CONV does nothing, and that after a flush aborts a conversion a new start is accepted at once; a design that failed to leave CONV would swallow that start. Finally it checks standby gating with each value of `run_stby`, a reset applied in the middle of the delay, and `en`=0 holding back all three pulses.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_READY = 2'd1,
        ST_WARM  = 2'd2,
        ST_CONV  = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/adc_pwr_policy.sv
// Decodes the enable / standby / on-demand bits into an allow flag and mode.
module adc_pwr_policy (
    input  logic en,
    input  logic run_stby,
    input  logic on_demand,
    input  logic in_standby,
    output logic allowed,
    output logic ondem_mode
);
    always_comb begin
        allowed    = en && (!in_standby || run_stby);
        ondem_mode = on_demand;
    end
endmodule

// File: rtl/adc_evt_merge.sv
// ORs the event lines of each group and gives flush priority over start.
module adc_evt_merge #(
    parameter int N_EVT = 4
) (
    input  logic [N_EVT-1:0] evt_start,
    input  logic [N_EVT-1:0] evt_flush,
    output logic             start_req,
    output logic             flush_req
);
    logic [N_EVT:0] start_or;
    logic [N_EVT:0] flush_or;

    assign start_or[0] = 1'b0;
    assign flush_or[0] = 1'b0;

    for (genvar i = 0; i < N_EVT; i++) begin : g_or
        assign start_or[i+1] = start_or[i] | evt_start[i];
        assign flush_or[i+1] = flush_or[i] | evt_flush[i];
    end

    always_comb begin
        flush_req = flush_or[N_EVT];
        start_req = start_or[N_EVT] && !flush_or[N_EVT];
    end
endmodule

// File: rtl/adc_su_timer.sv
// Start-up delay down-counter.
module adc_su_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [DLY_W-1:0] load_val,
    output logic             zero
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_pwr_fsm.sv
// Power / conversion sequencing state machine.
module adc_pwr_fsm
    import adc_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic allowed,
    input  logic ondem_mode,
    input  logic start_req,
    input  logic flush_req,
    input  logic conv_done,
    input  logic timer_zero,
    output logic timer_load,
    output logic timer_dec,
    output logic ana_pwr,
    output logic conv_start,
    output logic flush_pulse,
    output logic wake_req
);
    pwr_state_t st_q, st_d;
    logic       do_start, do_wake, do_flush;

    // next-state and action decode
    always_comb begin
        st_d       = st_q;
        do_start   = 1'b0;
        do_wake    = 1'b0;
        do_flush   = 1'b0;
        timer_load = 1'b0;
        timer_dec  = 1'b0;
        if (!allowed) begin
            st_d     = ST_OFF;
            do_flush = en && flush_req;
        end else if (flush_req) begin
            do_flush = 1'b1;
            st_d     = ondem_mode ? ST_OFF : ST_READY;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    if (!ondem_mode) begin
                        st_d = ST_READY;
                    end else if (start_req) begin
                        st_d       = ST_WARM;
                        do_wake    = 1'b1;
                        timer_load = 1'b1;
                    end
                end
                ST_READY: begin
                    if (ondem_mode) begin
                        st_d = ST_OFF;
                    end else if (start_req) begin
                        st_d     = ST_CONV;
                        do_start = 1'b1;
                    end
                end
                ST_WARM: begin
                    if (timer_zero) begin
                        st_d     = ST_CONV;
                        do_start = 1'b1;
                    end else begin
                        timer_dec = 1'b1;
                    end
                end
                ST_CONV: begin
                    if (conv_done) begin
                        st_d = ondem_mode ? ST_OFF : ST_READY;
                    end
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            ana_pwr     <= 1'b0;
            conv_start  <= 1'b0;
            flush_pulse <= 1'b0;
            wake_req    <= 1'b0;
        end else begin
            ana_pwr     <= (st_d != ST_OFF);
            conv_start  <= do_start;
            flush_pulse <= do_flush;
            wake_req    <= do_wake;
        end
    end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
    parameter int N_EVT = 4,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             run_stby,
    input  logic             on_demand,
    input  logic             in_standby,
    input  logic [N_EVT-1:0] evt_start,
    input  logic [N_EVT-1:0] evt_flush,
    input  logic             conv_done,
    input  logic [DLY_W-1:0] su_delay,
    output logic             ana_pwr,
    output logic             conv_start,
    output logic             flush_pulse,
    output logic             wake_req
);
    logic allowed, ondem_mode, start_req, flush_req;
    logic timer_load, timer_dec, timer_zero;

    adc_pwr_policy u_policy (
        .en        (en),
        .run_stby  (run_stby),
        .on_demand (on_demand),
        .in_standby(in_standby),
        .allowed   (allowed),
        .ondem_mode(ondem_mode)
    );

    adc_evt_merge #(.N_EVT(N_EVT)) u_evt (
        .evt_start(evt_start),
        .evt_flush(evt_flush),
        .start_req(start_req),
        .flush_req(flush_req)
    );

    adc_su_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .dec     (timer_dec),
        .load_val(su_delay),
        .zero    (timer_zero)
    );

    adc_pwr_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .allowed    (allowed),
        .ondem_mode (ondem_mode),
        .start_req  (start_req),
        .flush_req  (flush_req),
        .conv_done  (conv_done),
        .timer_zero (timer_zero),
        .timer_load (timer_load),
        .timer_dec  (timer_dec),
        .ana_pwr    (ana_pwr),
        .conv_start (conv_start),
        .flush_pulse(flush_pulse),
        .wake_req   (wake_req)
    );
endmodule

// File: rtl/adc_pwr_chk.sv
module adc_pwr_chk #(
    parameter int N_EVT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             run_stby,
    input logic             in_standby,
    input logic [N_EVT-1:0] evt_flush,
    input logic             ana_pwr,
    input logic             conv_start,
    input logic             flush_pulse,
    input logic             wake_req
);
    // R1
    en_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ana_pwr && !conv_start && !wake_req && !flush_pulse));

    // R2
    stby_block_chk: assert property (@(posedge clk) disable iff (rst)
        (en && in_standby && !run_stby) |=> (!ana_pwr && !conv_start));

    // R8
    flush_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (|evt_flush)) |=> (flush_pulse && !conv_start));

    // R9
    start_once_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({conv_start, wake_req, flush_pulse}));

    // R5
    wake_pwr_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> ana_pwr);

    // R4
    start_pwr_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> ana_pwr);
endmodule

bind adc_pwr_seq adc_pwr_chk #(.N_EVT(N_EVT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .run_stby   (run_stby),
    .in_standby (in_standby),
    .evt_flush  (evt_flush),
    .ana_pwr    (ana_pwr),
    .conv_start (conv_start),
    .flush_pulse(flush_pulse),
    .wake_req   (wake_req)
);

// File: tb/sim_adc_pwr_seq.sv
`timescale 1ns/1ps
module sim_adc_pwr_seq;
    localparam int N_EVT = 4;
    localparam int DLY_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0, run_stby = 1'b0, on_demand = 1'b0, in_standby = 1'b0;
    logic [N_EVT-1:0] evt_start = '0, evt_flush = '0;
    logic             conv_done = 1'b0;
    logic [DLY_W-1:0] su_delay = '0;
    logic             ana_pwr, conv_start, flush_pulse, wake_req;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    adc_pwr_seq #(.N_EVT(N_EVT), .DLY_W(DLY_W)) u0 (
        .clk(clk), .rst(rst), .en(en), .run_stby(run_stby),
        .on_demand(on_demand), .in_standby(in_standby),
        .evt_start(evt_start), .evt_flush(evt_flush),
        .conv_done(conv_done), .su_delay(su_delay),
        .ana_pwr(ana_pwr), .conv_start(conv_start),
        .flush_pulse(flush_pulse), .wake_req(wake_req)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        chk("R10", "ana_pwr in reset", ana_pwr, 1'b0);
        chk("R10", "conv_start in reset", conv_start, 1'b0);
        chk("R10", "wake_req in reset", wake_req, 1'b0);
        rst = 1'b0;
        step();
        chk("R10", "ana_pwr idle after reset", ana_pwr, 1'b0);
    endtask

    task automatic t_continuous();
        en = 1; on_demand = 0; in_standby = 0; run_stby = 0;
        step();
        chk("R4", "power on after allow", ana_pwr, 1'b1);
        step();
        chk("R4", "power stays on", ana_pwr, 1'b1);
        evt_start = 4'b0100;
        step(); evt_start = '0;
        chk("R4", "start from READY", conv_start, 1'b1);
        step();
        chk("R9", "start is one cycle", conv_start, 1'b0);
        evt_start = 4'b0001;
        step(); evt_start = '0;
        chk("R9", "start ignored in CONV", conv_start, 1'b0);
        conv_done = 1;
        step(); conv_done = 0;
        chk("R4", "power kept after done", ana_pwr, 1'b1);
        evt_start = 4'b1000;
        step(); evt_start = '0;
        chk("R7", "top event bit starts", conv_start, 1'b1);
        conv_done = 1;
        step(); conv_done = 0;
    endtask

    task automatic t_standby();
        en = 1; on_demand = 0; run_stby = 0; in_standby = 1;
        step();
        chk("R2", "power off in standby", ana_pwr, 1'b0);
        evt_start = 4'b0010;
        step(); evt_start = '0;
        chk("R2", "no start in standby", conv_start, 1'b0);
        in_standby = 0;
        step();
        chk("R2", "runs in other sleep", ana_pwr, 1'b1);
        run_stby = 1; in_standby = 1;
        step();
        chk("R3", "power on in standby", ana_pwr, 1'b1);
        evt_start = 4'b0010;
        step(); evt_start = '0;
        chk("R3", "start in standby", conv_start, 1'b1);
        conv_done = 1;
        step(); conv_done = 0;
        in_standby = 0; run_stby = 0;
    endtask

    task automatic t_ondemand(input int dly);
        en = 1; on_demand = 1; su_delay = DLY_W'(dly);
        step();
        chk("R5", "power off when idle on demand", ana_pwr, 1'b0);
        evt_start = 4'b0001;
        step(); evt_start = '0;
        chk("R5", "wake pulse", wake_req, 1'b1);
        chk("R5", "power on with wake", ana_pwr, 1'b1);
        chk("R5", "no early start", conv_start, 1'b0);
        for (int i = 1; i <= dly; i++) begin
            step();
            chk("R5", "start held during delay", conv_start, 1'b0);
        end
        step();
        chk("R5", "start after delay", conv_start, 1'b1);
        chk("R9", "wake is one cycle", wake_req, 1'b0);
        conv_done = 1;
        step(); conv_done = 0;
        chk("R6", "power off after done", ana_pwr, 1'b0);
    endtask

    task automatic t_flush();
        en = 1; on_demand = 0;
        step(); step();
        evt_start = 4'b0001; evt_flush = 4'b0100;
        step(); evt_start = '0; evt_flush = '0;
        chk("R8", "flush wins pulse", flush_pulse, 1'b1);
        chk("R8", "start suppressed", conv_start, 1'b0);
        step();
        chk("R9", "flush is one cycle", flush_pulse, 1'b0);
        evt_start = 4'b0001;
        step(); evt_start = '0;
        chk("R8", "conv starts", conv_start, 1'b1);
        evt_flush = 4'b0001;
        step(); evt_flush = '0;
        chk("R8", "flush during CONV", flush_pulse, 1'b1);
        evt_start = 4'b0010;
        step(); evt_start = '0;
        chk("R8", "CONV abandoned, start accepted", conv_start, 1'b1);
        conv_done = 1;
        step(); conv_done = 0;
        on_demand = 1; su_delay = 8'd5;
        step();
        evt_start = 4'b0001;
        step(); evt_start = '0;
        step();
        evt_flush = 4'b1000;
        step(); evt_flush = '0;
        chk("R8", "flush in WARM powers off", ana_pwr, 1'b0);
    endtask

    task automatic t_disabled();
        en = 0; on_demand = 0;
        step();
        chk("R1", "power off when disabled", ana_pwr, 1'b0);
        evt_start = 4'b1111;
        step(); evt_start = '0;
        chk("R1", "no start when disabled", conv_start, 1'b0);
        chk("R1", "no wake when disabled", wake_req, 1'b0);
        evt_flush = 4'b1111;
        step(); evt_flush = '0;
        chk("R1", "no flush when disabled", flush_pulse, 1'b0);
    endtask

    task automatic t_reset_mid();
        en = 1; on_demand = 1; su_delay = 8'd4;
        step();
        evt_start = 4'b0001;
        step(); evt_start = '0;
        step();
        rst = 1;
        step();
        chk("R10", "reset drops power", ana_pwr, 1'b0);
        rst = 0;
        step();
        chk("R10", "no start after reset", conv_start, 1'b0);
        su_delay = 8'd2;
        evt_start = 4'b0001;
        step(); evt_start = '0;
        chk("R10", "wake after reset", wake_req, 1'b1);
        step(); step();
        chk("R10", "full delay after reset", conv_start, 1'b0);
        step();
        chk("R10", "start after full delay", conv_start, 1'b1);
    endtask

    initial begin
        step();
        t_reset();
        t_continuous();
        t_standby();
        t_ondemand(3);
        t_ondemand(0);
        t_flush();
        t_disabled();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule